// File: doc/BRIEF.md
# Configuration Command and Status Registers

This block keeps the command word, the status word and the cache line size byte of a type-0 configuration header for an agent on a conventional parallel bus. Configuration software reaches it through a 32-bit read/write port with a dword address and four byte enables. Reads are registered: the data appears one cycle after the read strobe, together with a valid flag. The two 16-bit words share one dword. The command word is the low half, at byte offsets 4 and 5. The status word is the high half, at byte offsets 6 and 7. The cache line size is the lowest byte of dword 3 (byte offset 12). Every other dword reads as zero, and writes to it are dropped.

The rest of the bus logic reports what happened through single-cycle event pulses. These cover a parity error, a data parity error seen while mastering, a master abort (with a flag for special cycles), a target abort that was received, a target abort that was signalled, and a request to drive the system error line. A level input carries the internal interrupt request. The status error bits are sticky. An event sets them, and software clears them by writing 1. Several of them, and the two error line drive enables, are qualified by command bits. The interrupt request to the bus is masked by the interrupt disable bit, while its raw state stays visible in the status word.

Top module: `cfg_cmd_status`

## Requirements
- R1: After a synchronous reset, all writable command bits, all sticky status bits and the cache line size read as 0. The enable and request outputs are 0.
- R2: Command bits 0, 1, 2, 6, 8 and 10 are writable. Bit 0 enables I/O decode, bit 1 memory decode, bit 2 bus mastering, bit 6 parity error response, bit 8 the system error driver, and bit 10 disables the interrupt. All other command bits always read 0, so the writable mask is 0x0547.
- R3: `io_en`, `mem_en` and `bus_master_en` equal command bits 0, 1 and 2 in the cycle after the write.
- R4: Status bits 15, 14, 13, 12, 11 and 8 are cleared by writing 1 to them, in the cycle after the write. A 0 written to them leaves them unchanged.
- R5: A parity error pulse sets status bit 15 whatever the value of command bit 6. `perr_drive` is high during the pulse only when command bit 6 is 1.
- R6: A master data parity error pulse sets status bit 8 only when command bit 6 is 1.
- R7: A master abort pulse sets status bit 13 unless `ev_special_cycle` is high in the same cycle.
- R8: `serr_drive` is high during a `serr_req` pulse only when command bit 8 is 1. Status bit 14 is set exactly when `serr_drive` was high.
- R9: A received target abort pulse sets status bit 12. A signalled target abort pulse sets status bit 11.
- R10: Status bit 3 follows `int_pending` live. `intx_req` is high only when `int_pending` is 1 and command bit 10 is 0.
- R11: With the default parameters, the read-only status bits are fixed. Bits 10:9 hold the select timing code 1 (0 fast, 1 medium, 2 slow). Bit 7 (back-to-back capable) is 0, bit 5 (66 MHz) is 0, and bit 4 (capability pointer at 0x34) is 1. The idle status word is therefore 0x0210.
- R12: If a set event and a write-1-to-clear hit the same sticky bit in the same cycle, the bit stays set.
- R13: A write to the cache line size stores the value if it is 0, or a power of two no larger than `CLS_MAX` (default 32). Any other value stores 0.
- R14: Each byte enable gates its own byte lane. A write to an unmapped dword changes nothing. Reads of unmapped dwords return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | ADDR_W | Dword address of the configuration access |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| cfg_be | input | 4 | Byte enables, bit n selects byte lane n |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, registered |
| cfg_rvalid | output | 1 | Read data valid, one cycle after `cfg_rd` |
| ev_parity_err | input | 1 | Parity error detected |
| ev_master_perr | input | 1 | Data parity error on a transfer this agent mastered |
| ev_master_abort | input | 1 | Mastered transaction ended in master abort |
| ev_special_cycle | input | 1 | The aborted transaction was a special cycle |
| ev_tabort_rcvd | input | 1 | Mastered transaction ended in target abort |
| ev_tabort_sig | input | 1 | This target ended a transaction with target abort |
| serr_req | input | 1 | Request to drive the system error line |
| int_pending | input | 1 | Internal interrupt request, level |
| io_en | output | 1 | I/O space decode enable |
| mem_en | output | 1 | Memory space decode enable |
| bus_master_en | output | 1 | Bus master enable |
| perr_drive | output | 1 | Parity error line drive enable |
| serr_drive | output | 1 | System error line drive enable |
| intx_req | output | 1 | Gated interrupt request |

## Verification
The assertions check on every cycle that sticky bits follow their events. They cover the parity error bit, the gated master abort bit, target abort priority over a same-cycle clear, and the system error flag following its drive. They also check that the master data parity bit only rises while parity response is on, and that the cache line size always holds a legal value. Only the bench scenarios can show the rest. These are the byte-lane masking of writes, the refusal of writes to other dwords, that writing zeros leaves status unchanged, and the fixed read-only code fields. They also include the interrupt masking while the raw status stays visible, and the exact values read back after each sequence of events and clears.

// File: rtl/cfgcs_pkg.sv
package cfgcs_pkg;

    localparam int CMD_BYTE_OFF = 4;
    localparam int CLS_BYTE_OFF = 12;
    localparam logic [15:0] CMD_RW_MASK = 16'h0547;

    typedef struct packed {
        logic int_dis;
        logic serr_en;
        logic parity_resp;
        logic bus_master;
        logic mem_space;
        logic io_space;
    } cmd_t;

    typedef struct packed {
        logic det_par;
        logic sig_serr;
        logic rcv_mabort;
        logic rcv_tabort;
        logic sig_tabort;
        logic mdpe;
    } sticky_t;

    typedef struct packed {
        logic parity_err;
        logic master_perr;
        logic master_abort;
        logic special_cycle;
        logic tabort_rcvd;
        logic tabort_sig;
        logic serr_req;
    } event_t;

    function automatic logic [15:0] pack_cmd(cmd_t c);
        logic [15:0] w;
        w     = '0;
        w[0]  = c.io_space;
        w[1]  = c.mem_space;
        w[2]  = c.bus_master;
        w[6]  = c.parity_resp;
        w[8]  = c.serr_en;
        w[10] = c.int_dis;
        return w;
    endfunction

    function automatic cmd_t unpack_cmd(logic [15:0] w);
        cmd_t c;
        c.io_space    = w[0];
        c.mem_space   = w[1];
        c.bus_master  = w[2];
        c.parity_resp = w[6];
        c.serr_en     = w[8];
        c.int_dis     = w[10];
        return c;
    endfunction

    function automatic sticky_t unpack_sticky(logic [15:0] w);
        sticky_t s;
        s.det_par    = w[15];
        s.sig_serr   = w[14];
        s.rcv_mabort = w[13];
        s.rcv_tabort = w[12];
        s.sig_tabort = w[11];
        s.mdpe       = w[8];
        return s;
    endfunction

    function automatic logic [15:0] pack_status(sticky_t s, logic int_st, logic [1:0] devsel,
                                                logic fb2b, logic m66, logic caps);
        logic [15:0] w;
        w       = '0;
        w[15]   = s.det_par;
        w[14]   = s.sig_serr;
        w[13]   = s.rcv_mabort;
        w[12]   = s.rcv_tabort;
        w[11]   = s.sig_tabort;
        w[10:9] = devsel;
        w[8]    = s.mdpe;
        w[7]    = fb2b;
        w[5]    = m66;
        w[4]    = caps;
        w[3]    = int_st;
        return w;
    endfunction

    function automatic logic cls_legal(logic [7:0] v, logic [7:0] vmax);
        return ((v & (v - 8'd1)) == 8'd0) && (v <= vmax);
    endfunction

endpackage

// File: rtl/cfgcs_cmd_reg.sv
module cfgcs_cmd_reg
    import cfgcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  be,
    input  logic [15:0] wdata,
    output cmd_t        cmd_q,
    output logic [15:0] cmd_word
);
    localparam int LANES = 2;

    logic [15:0] merged;

    assign cmd_word = pack_cmd(cmd_q);

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign merged[g*8 +: 8] = be[g] ? wdata[g*8 +: 8] : cmd_word[g*8 +: 8];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)        cmd_q <= '0;
        else if (wr_en) cmd_q <= unpack_cmd(merged);
    end

    a_r2_rw_only: assert property (@(posedge clk) disable iff (rst)
        wr_en && (be == 2'b11) |=> (cmd_word == ($past(wdata) & CMD_RW_MASK)));
endmodule

// File: rtl/cfgcs_status_reg.sv
module cfgcs_status_reg
    import cfgcs_pkg::*;
#(
    parameter logic [1:0] DEVSEL_CODE = 2'd1,
    parameter bit         FB2B_CAP    = 1'b0,
    parameter bit         CAP_66MHZ   = 1'b0,
    parameter bit         HAS_CAPS    = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  event_t      ev,
    input  cmd_t        cmd,
    input  logic        int_pending,
    input  logic        clr_wr,
    input  logic [15:0] clr_bits,
    output logic [15:0] status_word,
    output logic        perr_drive,
    output logic        serr_drive
);
    sticky_t sticky_q, set_v, clr_v;

    assign perr_drive = ev.parity_err & cmd.parity_resp;
    assign serr_drive = ev.serr_req & cmd.serr_en;

    always_comb begin
        set_v.det_par    = ev.parity_err;
        set_v.sig_serr   = serr_drive;
        set_v.rcv_mabort = ev.master_abort & ~ev.special_cycle;
        set_v.rcv_tabort = ev.tabort_rcvd;
        set_v.sig_tabort = ev.tabort_sig;
        set_v.mdpe       = ev.master_perr & cmd.parity_resp;
        clr_v            = clr_wr ? unpack_sticky(clr_bits) : sticky_t'('0);
    end

    always_ff @(posedge clk) begin
        if (rst) sticky_q <= '0;
        else     sticky_q <= sticky_t'((sticky_q & ~clr_v) | set_v);
    end

    assign status_word = pack_status(sticky_q, int_pending, DEVSEL_CODE,
                                     FB2B_CAP, CAP_66MHZ, HAS_CAPS);

    a_r5_parity_sticks: assert property (@(posedge clk) disable iff (rst)
        ev.parity_err |=> status_word[15]);
    a_r6_mdpe_needs_resp: assert property (@(posedge clk) disable iff (rst)
        $rose(status_word[8]) |-> $past(cmd.parity_resp));
    a_r7_mabort_gated: assert property (@(posedge clk) disable iff (rst)
        ev.master_abort && !ev.special_cycle |=> status_word[13]);
    a_r12_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        ev.tabort_rcvd && clr_wr && clr_bits[12] |=> status_word[12]);
endmodule

// File: rtl/cfgcs_cls_reg.sv
module cfgcs_cls_reg
    import cfgcs_pkg::*;
#(
    parameter int CLS_MAX = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] cls_q
);
    localparam logic [7:0] CLS_LIMIT = 8'(CLS_MAX);

    always_ff @(posedge clk) begin
        if (rst)        cls_q <= '0;
        else if (wr_en) cls_q <= cls_legal(wdata, CLS_LIMIT) ? wdata : 8'd0;
    end

    a_r13_cls_legal: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cls_q) && (cls_q <= CLS_LIMIT));
endmodule

// File: rtl/cfg_cmd_status.sv
module cfg_cmd_status
    import cfgcs_pkg::*;
#(
    parameter int         ADDR_W      = 6,
    parameter int         CLS_MAX     = 32,
    parameter logic [1:0] DEVSEL_CODE = 2'd1,
    parameter bit         FB2B_CAP    = 1'b0,
    parameter bit         CAP_66MHZ   = 1'b0,
    parameter bit         HAS_CAPS    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              cfg_rvalid,
    input  logic              ev_parity_err,
    input  logic              ev_master_perr,
    input  logic              ev_master_abort,
    input  logic              ev_special_cycle,
    input  logic              ev_tabort_rcvd,
    input  logic              ev_tabort_sig,
    input  logic              serr_req,
    input  logic              int_pending,
    output logic              io_en,
    output logic              mem_en,
    output logic              bus_master_en,
    output logic              perr_drive,
    output logic              serr_drive,
    output logic              intx_req
);
    localparam int BYTES = 4;
    localparam logic [ADDR_W-1:0] CMD_DW = ADDR_W'(CMD_BYTE_OFF / BYTES);
    localparam logic [ADDR_W-1:0] CLS_DW = ADDR_W'(CLS_BYTE_OFF / BYTES);

    logic [31:0] lane_mask, masked_wdata, rd_next;
    logic [15:0] cmd_word, status_word;
    logic [7:0]  cls_q;
    logic        hit_cmd, hit_cls;
    cmd_t        cmd_q;
    event_t      ev;

    generate
        for (genvar g = 0; g < BYTES; g++) begin : g_mask
            assign lane_mask[g*8 +: 8] = {8{cfg_be[g]}};
        end
    endgenerate

    assign masked_wdata = cfg_wdata & lane_mask;
    assign hit_cmd      = cfg_wr && (cfg_addr == CMD_DW);
    assign hit_cls      = cfg_wr && (cfg_addr == CLS_DW) && cfg_be[0];

    assign ev = '{parity_err:    ev_parity_err,
                  master_perr:   ev_master_perr,
                  master_abort:  ev_master_abort,
                  special_cycle: ev_special_cycle,
                  tabort_rcvd:   ev_tabort_rcvd,
                  tabort_sig:    ev_tabort_sig,
                  serr_req:      serr_req};

    cfgcs_cmd_reg u_cmd (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (hit_cmd),
        .be       (cfg_be[1:0]),
        .wdata    (cfg_wdata[15:0]),
        .cmd_q    (cmd_q),
        .cmd_word (cmd_word)
    );

    cfgcs_status_reg #(
        .DEVSEL_CODE (DEVSEL_CODE),
        .FB2B_CAP    (FB2B_CAP),
        .CAP_66MHZ   (CAP_66MHZ),
        .HAS_CAPS    (HAS_CAPS)
    ) u_status (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .cmd         (cmd_q),
        .int_pending (int_pending),
        .clr_wr      (hit_cmd),
        .clr_bits    (masked_wdata[31:16]),
        .status_word (status_word),
        .perr_drive  (perr_drive),
        .serr_drive  (serr_drive)
    );

    cfgcs_cls_reg #(.CLS_MAX(CLS_MAX)) u_cls (
        .clk   (clk),
        .rst   (rst),
        .wr_en (hit_cls),
        .wdata (cfg_wdata[7:0]),
        .cls_q (cls_q)
    );

    assign io_en         = cmd_q.io_space;
    assign mem_en        = cmd_q.mem_space;
    assign bus_master_en = cmd_q.bus_master;
    assign intx_req      = int_pending & ~cmd_q.int_dis;

    always_comb begin
        if (cfg_addr == CMD_DW)      rd_next = {status_word, cmd_word};
        else if (cfg_addr == CLS_DW) rd_next = {24'd0, cls_q};
        else                         rd_next = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_rvalid <= 1'b0;
            cfg_rdata  <= '0;
        end else begin
            cfg_rvalid <= cfg_rd;
            if (cfg_rd) cfg_rdata <= rd_next;
        end
    end

    a_r8_serr_flagged: assert property (@(posedge clk) disable iff (rst)
        serr_drive |=> status_word[14]);
    a_r10_intx_masked: assert property (@(posedge clk) disable iff (rst)
        intx_req |-> (status_word[3] && !cmd_word[10]));
endmodule

// File: tb/test_cfg_cmd_status.sv
`timescale 1ns/1ps
module test_cfg_cmd_status;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  cfg_addr = '0;
    logic        cfg_wr = 0, cfg_rd = 0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_rvalid;
    logic ev_parity_err = 0, ev_master_perr = 0, ev_master_abort = 0, ev_special_cycle = 0;
    logic ev_tabort_rcvd = 0, ev_tabort_sig = 0, serr_req = 0, int_pending = 0;
    logic io_en, mem_en, bus_master_en, perr_drive, serr_drive, intx_req;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    cfg_cmd_status i_cfg_cmd_status (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
        .ev_parity_err(ev_parity_err), .ev_master_perr(ev_master_perr),
        .ev_master_abort(ev_master_abort), .ev_special_cycle(ev_special_cycle),
        .ev_tabort_rcvd(ev_tabort_rcvd), .ev_tabort_sig(ev_tabort_sig),
        .serr_req(serr_req), .int_pending(int_pending), .io_en(io_en), .mem_en(mem_en),
        .bus_master_en(bus_master_en), .perr_drive(perr_drive), .serr_drive(serr_drive),
        .intx_req(intx_req)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as the design returns it
    always @(negedge clk) begin
        if (cfg_rvalid && !rst) begin
            if (exp_q.size() == 0) check("unexpected read", cfg_rdata, 32'hxxxxxxxx);
            else check(tag_q.pop_front(), cfg_rdata, exp_q.pop_front());
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [5:0] a, logic [3:0] be, logic [31:0] d);
        cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1;
        step();
        cfg_wr = 0; cfg_be = '0;
    endtask

    task automatic rd(logic [5:0] a, logic [31:0] exp, string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        cfg_addr = a; cfg_rd = 1;
        step();
        cfg_rd = 0;
    endtask

    task automatic clear_ev();
        ev_parity_err = 0; ev_master_perr = 0; ev_master_abort = 0; ev_special_cycle = 0;
        ev_tabort_rcvd = 0; ev_tabort_sig = 0; serr_req = 0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state, R11 fixed fields
        check("R1 outputs", {26'd0, io_en, mem_en, bus_master_en, perr_drive, serr_drive, intx_req}, 32'd0);
        rd(6'd1, 32'h0210_0000, "R1 R11 cmd/status after reset");
        rd(6'd3, 32'h0000_0000, "R1 cls after reset");
        // R2 writable mask, R3 enables
        wr(6'd1, 4'b0011, 32'h0000_FFFF);
        check("R3 enables", {29'd0, io_en, mem_en, bus_master_en}, 32'd7);
        rd(6'd1, 32'h0210_0547, "R2 command mask");
        // R14 lane gating
        wr(6'd1, 4'b0001, 32'h0000_0000);
        check("R3 enables off", {29'd0, io_en, mem_en, bus_master_en}, 32'd0);
        wr(6'd1, 4'b1100, 32'hFFFF_FFFF);
        wr(6'd2, 4'b1111, 32'hFFFF_FFFF);
        rd(6'd1, 32'h0210_0500, "R14 byte lanes and unmapped write");
        rd(6'd2, 32'h0000_0000, "R14 unmapped read");
        // R5 parity with response off
        ev_parity_err = 1; #1;
        check("R5 perr_drive gated off", {31'd0, perr_drive}, 32'd0);
        step(); clear_ev();
        // R6 master perr with response off
        ev_master_perr = 1; step(); clear_ev();
        rd(6'd1, 32'h8210_0500, "R5 R6 parity sets 15 only");
        // response on
        wr(6'd1, 4'b0011, 32'h0000_0040);
        ev_master_perr = 1; step(); clear_ev();
        ev_parity_err = 1; #1;
        check("R5 perr_drive on", {31'd0, perr_drive}, 32'd1);
        step(); clear_ev();
        rd(6'd1, 32'h8310_0040, "R6 mdpe with response on");
        // R8 serr gating
        serr_req = 1; #1;
        check("R8 serr_drive gated off", {31'd0, serr_drive}, 32'd0);
        step(); clear_ev();
        rd(6'd1, 32'h8310_0040, "R8 no flag when disabled");
        wr(6'd1, 4'b0011, 32'h0000_0140);
        serr_req = 1; #1;
        check("R8 serr_drive on", {31'd0, serr_drive}, 32'd1);
        step(); clear_ev();
        rd(6'd1, 32'hC310_0140, "R8 flag when driven");
        // R7 master abort, R9 target aborts
        ev_master_abort = 1; ev_special_cycle = 1; step(); clear_ev();
        rd(6'd1, 32'hC310_0140, "R7 special cycle excluded");
        ev_master_abort = 1; step(); clear_ev();
        ev_tabort_rcvd = 1; step(); clear_ev();
        ev_tabort_sig = 1; step(); clear_ev();
        rd(6'd1, 32'hFB10_0140, "R7 R9 abort bits");
        // R4 write-1-to-clear
        wr(6'd1, 4'b1100, 32'h0000_0000);
        wr(6'd1, 4'b0100, 32'hFFFF_0000);
        rd(6'd1, 32'hFB10_0140, "R4 zeros and masked lane no effect");
        wr(6'd1, 4'b1000, 32'h8000_0000);
        wr(6'd1, 4'b1100, 32'h0100_0000);
        rd(6'd1, 32'h7A10_0140, "R4 clear bits 15 and 8");
        // R12 set beats clear
        ev_tabort_rcvd = 1;
        wr(6'd1, 4'b1000, 32'h1000_0000);
        clear_ev();
        rd(6'd1, 32'h7A10_0140, "R12 set wins");
        wr(6'd1, 4'b1000, 32'hFF00_0000);
        rd(6'd1, 32'h0210_0140, "R4 clear all");
        // R10 interrupt
        int_pending = 1; #1;
        check("R10 intx unmasked", {31'd0, intx_req}, 32'd1);
        step();
        rd(6'd1, 32'h0218_0140, "R10 status live");
        wr(6'd1, 4'b0011, 32'h0000_0540);
        check("R10 intx masked", {31'd0, intx_req}, 32'd0);
        rd(6'd1, 32'h0218_0540, "R10 raw status visible when masked");
        int_pending = 0;
        // R13 cache line size
        wr(6'd3, 4'b0001, 32'h0000_0010);
        rd(6'd3, 32'h0000_0010, "R13 legal 16");
        wr(6'd3, 4'b0001, 32'h0000_000C);
        rd(6'd3, 32'h0000_0000, "R13 non power of two");
        wr(6'd3, 4'b0001, 32'h0000_0020);
        wr(6'd3, 4'b0001, 32'h0000_0040);
        rd(6'd3, 32'h0000_0000, "R13 above limit");
        wr(6'd3, 4'b0001, 32'h0000_0020);
        wr(6'd3, 4'b1110, 32'h0000_0008);
        rd(6'd3, 32'h0000_0020, "R14 cls lane disabled");
        repeat (3) step();
        check("scoreboard drained", 32'(exp_q.size()), 32'd0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule